// File: doc/BRIEF.md
# Subcarrier Frame Encoder

This block turns a short burst of data bits into the switching signal for a tag's load modulator. A frame is a fixed start pattern of eight chips, then two chips for each data bit, then a fixed end pattern of eight chips. Each chip fills one slot of carrier time. In a 1-chip the modulation line toggles at the subcarrier rate, so the slot holds a whole number of subcarrier pulses. A 0-chip leaves the line low for the whole slot.

The encoder counts carrier-clock enables on `carrierTick` rather than system clock cycles, so the chip timing follows the field carrier at any system clock rate. A requester offers a bit count and a data word with a valid/ready handshake. The block then runs the frame by itself and reports `busy` until the last chip is over. CRC bytes are expected to be already part of the data word.

Top module: `sfe_top`

## Requirements
- R1: After reset `busy` and `modOut` are low and `inReady` is high.
- R2: A request is taken on a clock edge where `inValid` and `inReady` are both high. `busy` is high from the next cycle. `inReady` is low whenever `busy` is high, and requests offered while busy have no effect on the frame.
- R3: A chip slot lasts 2·SUB_HALF·PULSES carrier enables (512 by default). Inside a 1-chip the line is high for the first SUB_HALF enables of every 2·SUB_HALF window, which gives PULSES subcarrier pulses per slot.
- R4: A 0-chip keeps `modOut` low for its whole slot.
- R5: The frame opens with the chips 0,0,0,1,1,1,0,1 in that order (0x1D sent MSB first).
- R6: Data bits go out LSB first (bit 0 of `inData` first). A 1 is sent as chip 0 then chip 1, and a 0 is sent as chip 1 then chip 0.
- R7: The frame closes with the chips 1,0,1,1,1,0,0,0 in that order (0xB8 sent MSB first).
- R8: `busy` falls at the clock edge that uses up the last carrier enable of the final end chip. `modOut` is low whenever `busy` is low. A request held pending is taken on the very next edge.
- R9: A request with a count of 0 is consumed and starts no frame. A count above MAX_BITS is treated as MAX_BITS.
- R10: While `busy` is high and `carrierTick` is low, `modOut` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| carrierTick | input | 1 | One-cycle enable per carrier period |
| inValid | input | 1 | Request offered |
| inReady | output | 1 | Encoder can take a request |
| inCount | input | clog2(MAX_BITS+1) | Number of data bits in the frame |
| inData | input | MAX_BITS | Data bits, bit 0 sent first |
| modOut | output | 1 | Load-modulation control line |
| busy | output | 1 | Frame in progress |

## Verification
The end of a frame and the taking of the next request can fall in adjacent cycles, and they meet at the single cycle where `busy` is low. The bench keeps `inValid` high with a different word during a whole frame. It checks that this word changes nothing while the frame runs, that `busy` is low for exactly one sampled cycle after the final carrier enable, and that the following frame begins at chip zero with the new data. Carrier enables are also gated in an irregular pattern, which shows that slot timing follows the enables and not the clock.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SOF, PH_DATA, PH_EOF} phase_e;

  typedef struct packed {
    logic load;   // capture count and data, restart slot timer
    logic run;    // frame active: count carrier enables
    logic shift;  // move to the next data bit
  } strobe_t;

  localparam logic [7:0] SOF_CHIPS = 8'h1D;
  localparam logic [7:0] EOF_CHIPS = 8'hB8;
endpackage

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int SUB_HALF = 32,
  parameter int PULSES   = 8,
  parameter int MAX_BITS = 32,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                carrierTick,
  input  strobe_t             strb,
  input  logic [CNT_W-1:0]    inCount,
  input  logic [MAX_BITS-1:0] inData,
  input  logic                chipVal,
  output logic                chipEnd,
  output logic                curBit,
  output logic                lastBit,
  output logic                modOut
);
  localparam int CHIP_TICKS = 2 * SUB_HALF * PULSES;
  localparam int TICK_W     = $clog2(CHIP_TICKS);
  localparam int HALF_W     = $clog2(SUB_HALF);

  logic [TICK_W-1:0]   tickCnt;
  logic [MAX_BITS-1:0] dataReg;
  logic [CNT_W-1:0]    bitsLeft;
  logic [CNT_W-1:0]    clampCount;
  logic                subHigh;

  assign clampCount = (inCount > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : inCount;
  assign chipEnd    = strb.run && carrierTick && (tickCnt == TICK_W'(CHIP_TICKS - 1));
  assign subHigh    = ~tickCnt[HALF_W];
  assign curBit     = dataReg[0];
  assign lastBit    = (bitsLeft == CNT_W'(1));
  assign modOut     = strb.run & chipVal & subHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.load) begin
      tickCnt <= '0;
    end else if (strb.run && carrierTick) begin
      tickCnt <= chipEnd ? '0 : tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      bitsLeft <= '0;
    end else if (strb.load) begin
      dataReg  <= inData;
      bitsLeft <= clampCount;
    end else if (strb.shift) begin
      dataReg  <= dataReg >> 1;
      bitsLeft <= bitsLeft - 1'b1;
    end
  end
endmodule

// File: rtl/sfe_control.sv
module sfe_control
  import sfe_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CNT_W-1:0] inCount,
  input  logic             chipEnd,
  input  logic             curBit,
  input  logic             lastBit,
  output logic             inReady,
  output logic             busy,
  output strobe_t          strb,
  output logic             chipVal
);
  phase_e     phase;
  logic [2:0] patIdx;
  logic       secondHalf;

  assign inReady    = (phase == PH_IDLE);
  assign busy       = (phase != PH_IDLE);
  assign strb.load  = inValid && inReady && (inCount != '0);
  assign strb.run   = busy;
  assign strb.shift = (phase == PH_DATA) && chipEnd && secondHalf && !lastBit;

  always_comb begin
    case (phase)
      PH_SOF:  chipVal = SOF_CHIPS[3'd7 - patIdx];
      PH_DATA: chipVal = secondHalf ? curBit : !curBit;
      PH_EOF:  chipVal = EOF_CHIPS[3'd7 - patIdx];
      default: chipVal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      patIdx     <= '0;
      secondHalf <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (strb.load) begin
          phase  <= PH_SOF;
          patIdx <= '0;
        end
        PH_SOF: if (chipEnd) begin
          patIdx <= patIdx + 1'b1;
          if (patIdx == 3'd7) begin
            phase      <= PH_DATA;
            secondHalf <= 1'b0;
          end
        end
        PH_DATA: if (chipEnd) begin
          secondHalf <= !secondHalf;
          if (secondHalf && lastBit) begin
            phase  <= PH_EOF;
            patIdx <= '0;
          end
        end
        PH_EOF: if (chipEnd) begin
          patIdx <= patIdx + 1'b1;
          if (patIdx == 3'd7) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfe_top.sv
module sfe_top
  import sfe_pkg::*;
#(
  parameter int SUB_HALF = 32,
  parameter int PULSES   = 8,
  parameter int MAX_BITS = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             carrierTick,
  input  logic                             inValid,
  output logic                             inReady,
  input  logic [$clog2(MAX_BITS+1)-1:0]    inCount,
  input  logic [MAX_BITS-1:0]              inData,
  output logic                             modOut,
  output logic                             busy
);
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  strobe_t strb;
  logic    chipEnd, curBit, lastBit, chipVal;

  sfe_control #(.CNT_W(CNT_W)) u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCount(inCount),
    .chipEnd(chipEnd), .curBit(curBit), .lastBit(lastBit),
    .inReady(inReady), .busy(busy), .strb(strb), .chipVal(chipVal)
  );

  sfe_datapath #(.SUB_HALF(SUB_HALF), .PULSES(PULSES), .MAX_BITS(MAX_BITS)) u_datapath (
    .clk(clk), .rstN(rstN), .carrierTick(carrierTick), .strb(strb),
    .inCount(inCount), .inData(inData), .chipVal(chipVal),
    .chipEnd(chipEnd), .curBit(curBit), .lastBit(lastBit), .modOut(modOut)
  );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             carrierTick,
  input logic             inValid,
  input logic             inReady,
  input logic [CNT_W-1:0] inCount,
  input logic             modOut,
  input logic             busy
);
  assert_ready_blocked_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !inReady);

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCount != '0) |=> busy);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !modOut);

  assert_end_on_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(carrierTick));

  assert_empty_dropped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCount == '0) |=> !busy);

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !carrierTick) |=> ($stable(modOut) && busy));

  assert_sof_starts_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !modOut);
endmodule

bind sfe_top sfe_checker #(.CNT_W($clog2(MAX_BITS + 1))) u_sfeChecker (
  .clk(clk), .rstN(rstN), .carrierTick(carrierTick), .inValid(inValid),
  .inReady(inReady), .inCount(inCount), .modOut(modOut), .busy(busy)
);

// File: tb/test_sfe_top.sv
`timescale 1ns/1ps
module test_sfe_top;
  localparam int HALF  = 2;
  localparam int PULS  = 2;
  localparam int CHIP  = 2 * HALF * PULS;
  localparam int MAXB  = 32;
  localparam logic [7:0] SOFP = 8'h1D;
  localparam logic [7:0] EOFP = 8'hB8;

  // {gated, count, data}
  localparam int NVEC = 5;
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b0, 6'd8,  32'h0000_00A5},
    {1'b0, 6'd1,  32'h0000_0001},
    {1'b1, 6'd1,  32'h0000_0000},
    {1'b0, 6'd32, 32'hDEAD_BEEF},
    {1'b1, 6'd5,  32'h0000_0013}
  };

  logic clk = 0, rstN = 0, carrierTick = 0, inValid = 0;
  logic [5:0] inCount = '0;
  logic [31:0] inData = '0;
  logic inReady, modOut, busy;
  int nChecks = 0, nFails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  sfe_top #(.SUB_HALF(HALF), .PULSES(PULS), .MAX_BITS(MAXB)) i_sfe_top (
    .clk(clk), .rstN(rstN), .carrierTick(carrierTick), .inValid(inValid),
    .inReady(inReady), .inCount(inCount), .inData(inData),
    .modOut(modOut), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expChip(input int j, input int n, input logic [31:0] d);
    if (j < 8) return SOFP[7 - j];
    j -= 8;
    if (j < 2 * n) return (j % 2) ? d[j / 2] : !d[j / 2];
    j -= 2 * n;
    return EOFP[7 - j];
  endfunction

  // Called one step after the accepting edge; walks the whole frame.
  task automatic checkFrame(input int n, input logic [31:0] d, input bit gated, input string req);
    int k = 0, cyc = 0, errs = 0, firstK = -1, actV = 0, expV = 0;
    int total = (16 + 2 * n) * CHIP;
    while (k < total) begin
      bit e = expChip(k / CHIP, n, d) && ((k % (2 * HALF)) < HALF);
      bit t = gated ? (cyc % 3 != 0) : 1'b1;
      if (modOut !== e || busy !== 1'b1 || inReady !== 1'b0) begin
        if (errs == 0) begin firstK = k; actV = {busy, inReady, modOut}; expV = {2'b10, e}; end
        errs++;
      end
      carrierTick = t;
      @(posedge clk); #1;
      if (t) k++;
      cyc++;
    end
    check(errs == 0, req, actV, expV);
    if (errs != 0) $display("  first mismatch at enable %0d", firstK);
    check(busy === 1'b0 && modOut === 1'b0 && inReady === 1'b1,
          "R8 end of frame", {busy, modOut, inReady}, 3'b001);
  endtask

  task automatic startFrame(input int cnt, input logic [31:0] d);
    inValid = 1; inCount = 6'(cnt); inData = d;
    check(inReady === 1'b1, "R2 ready before request", inReady, 1);
    @(posedge clk); #1;
    inValid = 0;
    check(busy === 1'b1, "R2 busy after accept", busy, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy === 1'b0 && modOut === 1'b0 && inReady === 1'b1,
          "R1 reset state", {busy, modOut, inReady}, 3'b001);
    rstN = 1;
    @(posedge clk); #1;

    // Vector table: R3 R4 R5 R6 R7, gated entries cover R10
    for (int v = 0; v < NVEC; v++) begin
      startFrame(int'(VEC[v][37:32]), VEC[v][31:0]);
      checkFrame(int'(VEC[v][37:32]), VEC[v][31:0], VEC[v][38],
                 VEC[v][38] ? "R10 R3 gated frame" : "R3 R4 R5 R6 R7 frame");
    end

    // R9: zero count starts nothing
    inValid = 1; inCount = 0; inData = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    inValid = 0;
    repeat (2) @(posedge clk);
    #1;
    check(busy === 1'b0 && modOut === 1'b0, "R9 zero count ignored", {busy, modOut}, 0);

    // R9: count above MAX clamps to 32 bits
    startFrame(40, 32'h8000_0001);
    checkFrame(32, 32'h8000_0001, 1'b0, "R9 clamped count");

    // R2/R8: request held through a frame, taken right after it ends
    startFrame(2, 32'h0000_0002);
    inValid = 1; inCount = 6'd3; inData = 32'h0000_0005;
    checkFrame(2, 32'h0000_0002, 1'b0, "R2 pending request ignored while busy");
    @(posedge clk); #1;
    inValid = 0;
    check(busy === 1'b1, "R8 next request taken at once", busy, 1);
    checkFrame(3, 32'h0000_0005, 1'b1, "R8 back-to-back frame");

    // R10: no enables -> frame frozen at its first slot
    startFrame(1, 32'h1);
    carrierTick = 0;
    repeat (20) @(posedge clk);
    #1;
    check(busy === 1'b1 && modOut === 1'b0, "R10 frozen without enables", {busy, modOut}, 2'b10);
    checkFrame(1, 32'h1, 1'b0, "R10 frame resumes");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule